// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Controller (Master/Slave)

This block is an 8-bit SPI controller for a small processor core. The core sees two registers on a simple write/read bus. The control register sets the clock edge, the enable, the shift-enable (start) bit, the idle level of the data output and a 3-bit mode code. The data register takes the byte to send when written and returns the last received byte when read. Six mode codes make the block a master: it generates the serial clock itself, at a power-of-two fraction of the system clock. The two remaining codes make it a slave, clocked from outside, with the select input either obeyed or ignored.

A transfer starts when the core sets the shift-enable bit. The block then moves 8 bits MSB first. At the end it clears the shift-enable bit, places the received byte in the read register and sets a pending flag, which a read strobe clears. A slave can receive a second byte before the core has read the first. In that case the new byte is discarded and an overflow flag is raised. Signals coming from outside in slave mode pass through a two-stage synchronizer.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0x00, the read register reads 0x00, both output enables are low and `sdo` is 1.
- R2: Control register layout: bit 7 edge select, bit 6 enable, bit 5 overflow, bit 4 shift-enable, bit 3 idle-low, bits 2..0 mode. The shift-enable bit is set only if the same write also sets enable. While enable is 0, `sck_oe` and `sdo_oe` are 0.
- R3: A slave byte that completes while the previous byte is still unread sets bit 5 and leaves `rx_q` unchanged. A master never sets bit 5 and overwrites `rx_q`. A control write with bit 5 = 0 clears the flag; a write with bit 5 = 1 leaves it unchanged.
- R4: Mode codes 0 to 5 are master modes with a serial clock period of 2^(code+1) system clocks. The clock rests at the level of bit 7 whenever shift-enable is 0.
- R5: Bits move MSB first. With bit 7 = 0 data changes on the rising serial edge and is sampled on the falling edge; with bit 7 = 1 the two edges are swapped.
- R6: Shift-enable clears itself when the eighth bit is sampled, in the same cycle that `rx_q` takes the new byte.
- R7: Whenever shift-enable is 0, `sdo` equals the inverse of bit 3 (1 when bit 3 = 0, 0 when bit 3 = 1).
- R8: Mode 6 is a slave that obeys `ss_n`. While `ss_n` is high, `sdo_oe` is 0, serial edges are ignored and the bit count returns to zero. Mode 7 is a slave that ignores `ss_n`.
- R9: In slave mode a change on `sck_in` takes effect at the third rising edge of `clk` after the change.
- R10: A data-register read strobe (`rx_pop`) in the same cycle that a slave byte completes counts as reading the previous byte. The new byte is stored, stays pending, and no overflow is raised.
- R11: A data-register write while shift-enable is 1 is ignored. The byte to transmit persists across transfers until it is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects control, 1 selects data |
| bus_wdata | input | 8 | Write data |
| rx_pop | input | 1 | Data register read strobe |
| ctrl_q | output | 8 | Control register contents |
| rx_q | output | 8 | Last received byte |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Drive enable for the serial clock pin |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for the data output pin |

## Verification
Two events can land on the same clock edge: the core's read strobe on the data register and the completion of a slave byte that loads it. The bench knows the synchronizer latency, so it can predict the exact cycle in which a byte completes. It places the read strobe one cycle before, in, and one cycle after that cycle. For each placement the overflow flag and `rx_q` are compared with the arbitration rule: a read in or before the completing cycle prevents overflow, and a read one cycle late does not.

// File: rtl/spi_port.sv
module spi_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       rx_pop,
  output logic [7:0] ctrl_q,
  output logic [7:0] rx_q,
  input  logic       sck_in,
  output logic       sck_out,
  output logic       sck_oe,
  input  logic       ss_n,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe
);
  localparam int          NB      = 8;
  localparam int          CW      = $clog2(NB);
  localparam int          DIVW    = 6;
  localparam logic [2:0]  SL_SEL  = 3'b110;
  localparam logic [2:0]  SL_FREE = 3'b111;

  logic          edge_sel, en, ovf, go, idle_lo;
  logic [2:0]    mode;
  logic [NB-1:0] txb, sh, rxb;
  logic          out_r, data_ph, full, sck_r;
  logic [CW-1:0] bitcnt;
  logic [DIVW-1:0] div_cnt;
  logic [1:0]    sck_m, sel_m, sdi_m;
  logic          sck_d;

  wire slave  = mode[2] & mode[1];
  wire sel_ok = (mode == SL_FREE) || !sel_m[1];
  wire s_rise = sck_m[1] & ~sck_d;
  wire s_fall = ~sck_m[1] & sck_d;
  wire [DIVW-1:0] lim = (DIVW'(1) << mode) - DIVW'(1);

  wire m_tick = en && go && !slave && (div_cnt == lim);
  wire s_act  = en && go && slave && sel_ok;
  wire lead   = (m_tick && (sck_r == edge_sel)) ||
                (s_act && (edge_sel ? s_fall : s_rise));
  wire trail  = (m_tick && (sck_r != edge_sel)) ||
                (s_act && (edge_sel ? s_rise : s_fall));
  wire din    = slave ? sdi_m[1] : sdi;
  wire [NB-1:0] rx_next = {sh[NB-2:0], din};
  wire done    = trail && (bitcnt == CW'(NB - 1));
  wire lose    = done && slave && full && !rx_pop;
  wire ctrl_wr = bus_we && !bus_addr;
  wire data_wr = bus_we && bus_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_m <= 2'b00;
      sel_m <= 2'b11;
      sdi_m <= 2'b00;
      sck_d <= 1'b0;
    end else begin
      sck_m <= {sck_m[0], sck_in};
      sel_m <= {sel_m[0], ss_n};
      sdi_m <= {sdi_m[0], sdi};
      sck_d <= sck_m[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      edge_sel <= 1'b0;
      en       <= 1'b0;
      ovf      <= 1'b0;
      go       <= 1'b0;
      idle_lo  <= 1'b0;
      mode     <= '0;
      txb      <= '0;
      sh       <= '0;
      rxb      <= '0;
      out_r    <= 1'b0;
      data_ph  <= 1'b0;
      full     <= 1'b0;
      sck_r    <= 1'b0;
      bitcnt   <= '0;
      div_cnt  <= '0;
    end else begin
      if (m_tick) begin
        div_cnt <= '0;
        sck_r   <= ~sck_r;
      end else if (en && go && !slave) begin
        div_cnt <= div_cnt + DIVW'(1);
      end

      if (lead) begin
        data_ph <= 1'b1;
        if (bitcnt == '0) begin
          out_r <= txb[NB-1];
          sh    <= txb;
        end else begin
          out_r <= sh[NB-1];
        end
      end

      if (trail) begin
        sh     <= rx_next;
        bitcnt <= bitcnt + CW'(1);
      end

      if (done) begin
        go      <= 1'b0;
        data_ph <= 1'b0;
        if (!lose) rxb <= rx_next;
      end

      if (done && !lose) full <= 1'b1;
      else if (rx_pop)   full <= 1'b0;

      if (slave && mode == SL_SEL && sel_m[1]) begin
        bitcnt  <= '0;
        data_ph <= 1'b0;
      end

      if (data_wr && !go) txb <= bus_wdata;

      if (ctrl_wr) begin
        edge_sel <= bus_wdata[7];
        en       <= bus_wdata[6];
        go       <= bus_wdata[4] & bus_wdata[6];
        idle_lo  <= bus_wdata[3];
        mode     <= bus_wdata[2:0];
        sck_r    <= bus_wdata[7];
        div_cnt  <= '0;
        bitcnt   <= '0;
        data_ph  <= 1'b0;
        if (!bus_wdata[5]) ovf <= 1'b0;
      end

      if (lose) ovf <= 1'b1;
    end

  assign ctrl_q  = {edge_sel, en, ovf, go, idle_lo, mode};
  assign rx_q    = rxb;
  assign sck_out = sck_r;
  assign sck_oe  = en && !slave;
  assign sdo     = data_ph ? out_r : ~idle_lo;
  assign sdo_oe  = en && (!slave || sel_ok);
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl_q,
  input logic [7:0] rx_q,
  input logic       sdo,
  input logic       sdo_oe,
  input logic       sck_out,
  input logic       sck_oe,
  input logic       ss_n
);
  a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[6] |-> (!sck_oe && !sdo_oe));

  a_r2_go_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[4] |-> ctrl_q[6]);

  a_r3_slave_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[5]) |-> ($past(ctrl_q[2:1]) == 2'b11));

  a_r3_rx_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[5]) |-> $stable(rx_q));

  a_r4_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6] && ctrl_q[2:1] != 2'b11 && !ctrl_q[4]) |-> (sck_out == ctrl_q[7]));

  a_r7_sdo_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[4] |-> (sdo == !ctrl_q[3]));

  a_r8_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[2:0] == 3'b110 && ss_n && $past(ss_n) && $past(ss_n, 2)) |-> !sdo_oe);
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .rx_q(rx_q), .sdo(sdo),
  .sdo_oe(sdo_oe), .sck_out(sck_out), .sck_oe(sck_oe), .ss_n(ss_n)
);

// File: tb/spi_port_bench.sv
`timescale 1ns/1ps
module spi_port_bench;
  logic       clk = 1'b0;
  logic       rst_n, bus_we, bus_addr, rx_pop, sck_in, ss_n, sdi;
  logic [7:0] bus_wdata;
  logic [7:0] ctrl_q, rx_q;
  logic       sck_out, sck_oe, sdo, sdo_oe;
  int         total = 0, bad = 0;
  logic       cs_s = 1'b0;
  logic       g3, g4;

  always #4 clk = ~clk;

  spi_port u_spi_port (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rx_pop(rx_pop), .ctrl_q(ctrl_q), .rx_q(rx_q),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .ss_n(ss_n),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic m_xfer(input logic cs, input int md, input logic [7:0] sb,
                        output logic [7:0] got, output int pb);
    time t, tp;
    pb = 0; tp = 0; got = '0;
    for (int b = 0; b < 8; b++) begin
      wait (sck_out != cs);
      t = $time;
      #1;
      got[7-b] = sdo;
      sdi = sb[7-b];
      if (b > 0 && (t - tp) != (time'(8) << (md + 1))) pb++;
      tp = t;
      wait (sck_out == cs);
    end
  endtask

  task automatic s_xfer(input logic [7:0] mo, input int nb, input int rd_off,
                        output logic [7:0] mi);
    mi = '0;
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      sck_in = ~cs_s; sdi = mo[7-b];
      repeat (6) @(negedge clk);
      mi[7-b] = sdo;
      sck_in = cs_s;
      if (b < nb - 1) repeat (5) @(negedge clk);
    end
    if (nb == 8)
      for (int i = 1; i <= 6; i++) begin
        rx_pop = (i == rd_off);
        if (i == 3) g3 = ctrl_q[4];
        if (i == 4) g4 = ctrl_q[4];
        @(negedge clk);
      end
    rx_pop = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] tx, sb, got, mi, p, q;
    int pb;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
    rx_pop = 1'b0; sck_in = 1'b0; ss_n = 1'b1; sdi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl", ctrl_q, 8'h00);
    chk("R1 rx", rx_q, 8'h00);
    chk("R1 sck_oe", sck_oe, 0);
    chk("R1 sdo_oe", sdo_oe, 0);
    chk("R1 sdo", sdo, 1);

    wr(0, 8'h10);
    chk("R2 go needs enable", ctrl_q, 8'h00);
    chk("R2 off sck_oe", sck_oe, 0);
    chk("R2 off sdo_oe", sdo_oe, 0);
    wr(0, 8'h45);
    chk("R2 fields", ctrl_q, 8'h45);
    chk("R2 on sck_oe", sck_oe, 1);
    chk("R2 on sdo_oe", sdo_oe, 1);

    for (int cs = 0; cs < 2; cs++)
      for (int il = 0; il < 2; il++)
        for (int md = 0; md < 6; md++) begin
          tx = 8'(8'hA5 + (cs * 12 + il * 6 + md) * 29);
          sb = 8'(8'h3C ^ ((cs * 12 + il * 6 + md) * 53));
          wr(1, tx);
          wr(0, {cs[0], 1'b1, 1'b0, 1'b0, il[0], md[2:0]});
          @(negedge clk);
          chk("R4 sck idle before", sck_out, cs);
          chk("R7 sdo idle before", sdo, il == 0);
          wr(0, {cs[0], 1'b1, 1'b0, 1'b1, il[0], md[2:0]});
          m_xfer(cs[0], md, sb, got, pb);
          repeat (4) @(negedge clk);
          chk("R4 period", pb, 0);
          chk("R5 master out", got, tx);
          chk("R5 master in", rx_q, sb);
          chk("R6 go cleared", ctrl_q[4], 0);
          chk("R7 sdo idle after", sdo, il == 0);
          chk("R4 sck idle after", sck_out, cs);
          pop();
        end

    wr(1, 8'hC3);
    wr(0, 8'h53);
    fork
      begin repeat (20) @(negedge clk); wr(1, 8'h00); end
      m_xfer(1'b0, 3, 8'h81, got, pb);
    join
    chk("R11 write during transfer", got, 8'hC3);
    wr(0, 8'h53);
    m_xfer(1'b0, 3, 8'h18, got, pb);
    chk("R11 byte persists", got, 8'hC3);
    wr(1, 8'h5A);
    wr(0, 8'h53);
    m_xfer(1'b0, 3, 8'h18, got, pb);
    chk("R11 idle write", got, 8'h5A);
    pop();

    wr(0, 8'h50);
    m_xfer(1'b0, 0, 8'h6E, got, pb);
    wr(0, 8'h50);
    m_xfer(1'b0, 0, 8'h9D, got, pb);
    repeat (3) @(negedge clk);
    chk("R3 master no overflow", ctrl_q[5], 0);
    chk("R3 master overwrite", rx_q, 8'h9D);
    pop();

    for (int cs = 0; cs < 2; cs++)
      for (int m = 6; m < 8; m++) begin
        tx = 8'(8'h96 ^ (cs * 40 + m * 7));
        p  = 8'(8'h4B + cs * 77 + m * 13);
        cs_s = cs[0];
        wr(1, tx);
        sck_in = cs_s;
        ss_n = (m == 7);
        repeat (4) @(negedge clk);
        wr(0, {cs[0], 1'b1, 1'b0, 1'b1, 1'b0, 3'(m)});
        chk("R2 slave sck_oe", sck_oe, 0);
        chk("R8 slave sdo_oe", sdo_oe, 1);
        s_xfer(p, 8, 0, mi);
        repeat (4) @(negedge clk);
        chk("R5 slave out", mi, tx);
        chk("R5 slave in", rx_q, p);
        chk("R9 go before third edge", g3, 1);
        chk("R9 go after third edge", g4, 0);
        chk("R7 slave sdo idle", sdo, 1);
        pop();
      end

    cs_s = 1'b0; sck_in = 1'b0; ss_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int ro = 2; ro <= 4; ro++) begin
      p = 8'(8'h21 * ro + 3);
      q = 8'(8'hE7 - ro * 17);
      wr(0, 8'h47);
      pop();
      wr(0, 8'h57);
      s_xfer(p, 8, 0, mi);
      wr(0, 8'h57);
      s_xfer(q, 8, ro, mi);
      repeat (3) @(negedge clk);
      chk("R10 overflow by read cycle", ctrl_q[5], ro >= 4);
      chk("R10 rx by read cycle", rx_q, (ro >= 4) ? p : q);
      chk("R9 completion cycle", {g3, g4}, 2'b10);
    end
    chk("R3 overflow set", ctrl_q[5], 1);
    wr(0, 8'h67);
    chk("R3 write one keeps", ctrl_q[5], 1);
    wr(0, 8'h47);
    chk("R3 write zero clears", ctrl_q[5], 0);
    pop();
    wr(0, 8'h57);
    s_xfer(8'h0F, 8, 0, mi);
    wr(0, 8'h57);
    s_xfer(8'hF0, 8, 0, mi);
    repeat (3) @(negedge clk);
    chk("R3 slave overflow", ctrl_q[5], 1);
    chk("R3 slave rx kept", rx_q, 8'h0F);
    wr(0, 8'h47);
    pop();

    wr(1, 8'hB4);
    ss_n = 1'b1;
    wr(0, 8'h56);
    repeat (4) @(negedge clk);
    chk("R8 deselected sdo_oe", sdo_oe, 0);
    s_xfer(8'hFF, 8, 0, mi);
    repeat (4) @(negedge clk);
    chk("R8 edges ignored go", ctrl_q[4], 1);
    chk("R8 edges ignored rx", rx_q, 8'h0F);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    s_xfer(8'hAA, 3, 0, mi);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    s_xfer(8'h3D, 8, 0, mi);
    repeat (4) @(negedge clk);
    chk("R8 count reset out", mi, 8'hB4);
    chk("R8 count reset in", rx_q, 8'h3D);
    chk("R6 slave go cleared", ctrl_q[4], 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule